// File: doc/BRIEF.md
# Single-Channel DMA Transfer Engine

This block is one programmable DMA channel. It copies a programmed number of data items between two address windows, a peripheral side and a memory side. Each item is read from the source side and then written to the destination side. Both accesses go through a simple bus master port, and that port completes each access with a done or error strobe. Configuration is loaded from register-style inputs while the channel is stopped. Each side has its own base address, its own address increment enable and its own data width. A direction bit selects which side is the source.

In peripheral mode, every item waits for a request from the attached peripheral. The channel answers each request with a one-cycle acknowledge before it reads. In memory-to-memory mode the channel streams items back to back with no requests. In normal mode the channel stops when the count runs out. In circular mode it reloads the count and both base addresses and keeps going. Three sticky flags report progress and faults: half-transfer, transfer-complete and bus error. Software clears them by writing ones.

Top module: `dma_chan_engine`

## Requirements
- R1: After reset the channel is disabled, all three flags are 0, the remaining count is 0, and busReq and perAck are 0.
- R2: A cfgWe pulse loads the configuration and sets the remaining count to cfgCount only while the channel is disabled. A cfgWe pulse while it is enabled changes nothing.
- R3: If cfgMemIsSrc is 0, items are read from the peripheral side and written to the memory side. If it is 1, the roles are swapped. Each item is one read (busWrite=0) followed by one write (busWrite=1).
- R4: Width codes are 0 = byte, 1 = halfword, 2 or 3 = word, and busSize carries the code of the side being accessed. A side with its increment enabled advances by its width in bytes after each item. A side with increment disabled reuses its base address for every item.
- R5: Read data is taken from busRdata bits [8w-1:0], where w is the source width in bytes. It is written on busWdata zero-extended to the destination width, or truncated to its low bytes.
- R6: In peripheral mode (cfgMemToMem=0), no bus access starts without perReq. Each item is preceded by exactly one single-cycle perAck, and the read starts in the next cycle.
- R7: In memory-to-memory mode the channel transfers all items without perReq.
- R8: In normal mode, once the last item is written, remaining is 0, the channel disables itself and flagDone is set.
- R9: In circular mode, the last item sets flagDone and reloads the count and both base addresses, and the channel stays enabled.
- R10: flagHalf is set when an item write leaves remaining equal to floor(cfgCount/2).
- R11: A busErr response sets flagErr and disables the channel. The failed item is not counted, so remaining keeps its value.
- R12: Writing the enable to 0 stops the channel: busReq is 0 from the next cycle on, and remaining holds its value.
- R13: Flags are sticky. flagClr bit 0 clears flagHalf, bit 1 clears flagDone and bit 2 clears flagErr. A set event in the same cycle wins over a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWe | input | 1 | Load configuration (accepted only while disabled) |
| cfgPerBase | input | AW | Peripheral-side base address |
| cfgMemBase | input | AW | Memory-side base address |
| cfgMemIsSrc | input | 1 | 0: peripheral is the source, 1: memory is the source |
| cfgCount | input | CW | Number of items |
| cfgPerInc | input | 1 | Peripheral address increment enable |
| cfgMemInc | input | 1 | Memory address increment enable |
| cfgPerWidth | input | 2 | Peripheral width code |
| cfgMemWidth | input | 2 | Memory width code |
| cfgCircular | input | 1 | Circular reload mode |
| cfgMemToMem | input | 1 | Memory-to-memory mode, no requests needed |
| enWe | input | 1 | Write strobe for the enable bit |
| enVal | input | 1 | Enable value to write |
| flagClr | input | 3 | Write-one-to-clear: bit 0 half, bit 1 done, bit 2 error |
| perReq | input | 1 | Peripheral request |
| perAck | output | 1 | Peripheral acknowledge, one cycle per item |
| busReq | output | 1 | Bus access request, held until done or error |
| busWrite | output | 1 | 1 for a write, 0 for a read |
| busAddr | output | AW | Byte address of the access |
| busSize | output | 2 | Width code of the access |
| busWdata | output | 32 | Write data, right-aligned |
| busRdata | input | 32 | Read data, right-aligned |
| busDone | input | 1 | Access completed |
| busErr | input | 1 | Access failed |
| enabled | output | 1 | Channel enable state |
| remaining | output | CW | Items still to transfer |
| flagHalf | output | 1 | Half-transfer flag |
| flagDone | output | 1 | Transfer-complete flag |
| flagErr | output | 1 | Transfer-error flag |

## Verification
The bench builds the engine with a 16-bit address (AW=16) and an 8-bit count (CW=8). Transfers therefore fit in a 256-byte bus model that answers every access in the cycle it is requested. This allows the whole memory to be compared after each width, direction and increment combination. A transfer also completes in a few dozen cycles, so circular laps, mid-transfer aborts and an error on a chosen address can all be reached quickly.

// File: rtl/dmaeng_pkg.sv
`timescale 1ns/1ps
package dmaeng_pkg;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE} state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCfg;
    logic capture;
    logic advance;
    logic reload;
    logic readPhase;
  } strobe_t;

  function automatic logic [2:0] widthBytes(input logic [1:0] code);
    case (code)
      2'd0:    widthBytes = 3'd1;
      2'd1:    widthBytes = 3'd2;
      default: widthBytes = 3'd4;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] widthMask(input logic [1:0] code);
    case (code)
      2'd0:    widthMask = 32'h0000_00FF;
      2'd1:    widthMask = 32'h0000_FFFF;
      default: widthMask = 32'hFFFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/dmaeng_dpath.sv
`timescale 1ns/1ps
module dmaeng_dpath
  import dmaeng_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic              enQ,
  input  logic              cfgWe,
  input  logic [AW-1:0]     cfgPerBase,
  input  logic [AW-1:0]     cfgMemBase,
  input  logic              cfgMemIsSrc,
  input  logic [CW-1:0]     cfgCount,
  input  logic              cfgPerInc,
  input  logic              cfgMemInc,
  input  logic [1:0]        cfgPerWidth,
  input  logic [1:0]        cfgMemWidth,
  input  logic              cfgCircular,
  input  logic              cfgMemToMem,
  input  logic [DATA_W-1:0] busRdata,
  output logic [AW-1:0]     busAddr,
  output logic [1:0]        busSize,
  output logic [DATA_W-1:0] busWdata,
  output logic [CW-1:0]     remaining,
  output logic              remEmpty,
  output logic              lastItem,
  output logic              hitHalf,
  output logic              circQ,
  output logic              m2mQ
);
  localparam int PADW = AW - 3;

  logic [AW-1:0]     perBase, memBase, perAddr, memAddr;
  logic [CW-1:0]     countCfg;
  logic              memIsSrc, perInc, memInc;
  logic [1:0]        perW, memW;
  logic [DATA_W-1:0] dataReg;

  logic [AW-1:0] perStep, memStep;
  logic [1:0]    srcW, dstW;

  always_comb begin
    perStep = perInc ? {{PADW{1'b0}}, widthBytes(perW)} : '0;
    memStep = memInc ? {{PADW{1'b0}}, widthBytes(memW)} : '0;
    srcW    = memIsSrc ? memW : perW;
    dstW    = memIsSrc ? perW : memW;
    if (stb.readPhase) begin
      busAddr = memIsSrc ? memAddr : perAddr;
      busSize = srcW;
    end else begin
      busAddr = memIsSrc ? perAddr : memAddr;
      busSize = dstW;
    end
    busWdata = dataReg & widthMask(dstW);
    remEmpty = (remaining == '0);
    lastItem = (remaining == CW'(1));
    hitHalf  = ((remaining - CW'(1)) == (countCfg >> 1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      perBase <= '0; memBase <= '0; countCfg <= '0;
      memIsSrc <= 1'b0; perInc <= 1'b0; memInc <= 1'b0;
      perW <= 2'd0; memW <= 2'd0; circQ <= 1'b0; m2mQ <= 1'b0;
    end else if (stb.loadCfg) begin
      perBase <= cfgPerBase; memBase <= cfgMemBase; countCfg <= cfgCount;
      memIsSrc <= cfgMemIsSrc; perInc <= cfgPerInc; memInc <= cfgMemInc;
      perW <= cfgPerWidth; memW <= cfgMemWidth;
      circQ <= cfgCircular; m2mQ <= cfgMemToMem;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      perAddr   <= '0;
      memAddr   <= '0;
      remaining <= '0;
    end else if (stb.loadCfg) begin
      perAddr   <= cfgPerBase;
      memAddr   <= cfgMemBase;
      remaining <= cfgCount;
    end else if (stb.reload) begin
      perAddr   <= perBase;
      memAddr   <= memBase;
      remaining <= countCfg;
    end else if (stb.advance) begin
      perAddr   <= perAddr + perStep;
      memAddr   <= memAddr + memStep;
      remaining <= remaining - CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            dataReg <= '0;
    else if (stb.capture) dataReg <= busRdata & widthMask(srcW);
  end

  // R2: a configuration write while enabled leaves the stored settings alone
  p_cfg_frozen_r2: assert property (@(posedge clk) disable iff (!rstN)
    (enQ && cfgWe) |=> ($stable(countCfg) && $stable(perBase) && $stable(memBase)));

  // R8: the count only moves by one, or is reloaded
  p_count_steps_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.loadCfg && !stb.reload) |=>
      (remaining == $past(remaining) || remaining == $past(remaining) - CW'(1)));
endmodule

// File: rtl/dmaeng_ctrl.sv
`timescale 1ns/1ps
module dmaeng_ctrl
  import dmaeng_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWe,
  input  logic       enWe,
  input  logic       enVal,
  input  logic [2:0] flagClr,
  input  logic       perReq,
  input  logic       busDone,
  input  logic       busErr,
  input  logic       remEmpty,
  input  logic       lastItem,
  input  logic       hitHalf,
  input  logic       circQ,
  input  logic       m2mQ,
  output strobe_t    stb,
  output logic       perAck,
  output logic       busReq,
  output logic       busWrite,
  output logic       enQ,
  output logic       flagHalf,
  output logic       flagDone,
  output logic       flagErr
);
  state_e state, stateNext;
  logic   active, rdOk, wrOk, errEv, finishNormal;

  always_comb begin
    active        = enQ && !remEmpty;
    busReq        = enQ && (state != ST_IDLE);
    busWrite      = (state == ST_WRITE);
    perAck        = (state == ST_IDLE) && active && !m2mQ && perReq;
    errEv         = busReq && busErr;
    rdOk          = busReq && !busWrite && busDone && !busErr;
    wrOk          = busReq && busWrite && busDone && !busErr;
    finishNormal  = wrOk && lastItem && !circQ;
    stb.loadCfg   = cfgWe && !enQ;
    stb.capture   = rdOk;
    stb.reload    = wrOk && lastItem && circQ;
    stb.advance   = wrOk && !(lastItem && circQ);
    stb.readPhase = (state == ST_READ);

    stateNext = state;
    if (!enQ) stateNext = ST_IDLE;
    else begin
      case (state)
        ST_IDLE:  if (active && (m2mQ || perReq)) stateNext = ST_READ;
        ST_READ:  if (errEv) stateNext = ST_IDLE;
                  else if (rdOk) stateNext = ST_WRITE;
        ST_WRITE: if (errEv || wrOk) stateNext = ST_IDLE;
        default:  stateNext = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      enQ      <= 1'b0;
      flagHalf <= 1'b0;
      flagDone <= 1'b0;
      flagErr  <= 1'b0;
    end else begin
      state <= stateNext;
      if (errEv || finishNormal) enQ <= 1'b0;
      else if (enWe)             enQ <= enVal;
      flagHalf <= (flagHalf && !flagClr[0]) || (wrOk && hitHalf);
      flagDone <= (flagDone && !flagClr[1]) || (wrOk && lastItem);
      flagErr  <= (flagErr  && !flagClr[2]) || errEv;
    end
  end

  // R6: an acknowledge is followed by the read of that item
  p_ack_then_read_r6: assert property (@(posedge clk) disable iff (!rstN)
    perAck |=> (busReq && !busWrite));

  // R11: a failed access leaves the channel disabled
  p_err_disables_r11: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && busErr) |=> !enQ);

  // R12: writing the enable low silences the bus from the next cycle
  p_abort_quiet_r12: assert property (@(posedge clk) disable iff (!rstN)
    (enWe && !enVal) |=> !busReq);

  // R8: completion is only flagged after the final item
  p_done_after_last_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagDone) |-> $past(lastItem));
endmodule

// File: rtl/dma_chan_engine.sv
`timescale 1ns/1ps
module dma_chan_engine
  import dmaeng_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [AW-1:0]     cfgPerBase,
  input  logic [AW-1:0]     cfgMemBase,
  input  logic              cfgMemIsSrc,
  input  logic [CW-1:0]     cfgCount,
  input  logic              cfgPerInc,
  input  logic              cfgMemInc,
  input  logic [1:0]        cfgPerWidth,
  input  logic [1:0]        cfgMemWidth,
  input  logic              cfgCircular,
  input  logic              cfgMemToMem,
  input  logic              enWe,
  input  logic              enVal,
  input  logic [2:0]        flagClr,
  input  logic              perReq,
  output logic              perAck,
  output logic              busReq,
  output logic              busWrite,
  output logic [AW-1:0]     busAddr,
  output logic [1:0]        busSize,
  output logic [DATA_W-1:0] busWdata,
  input  logic [DATA_W-1:0] busRdata,
  input  logic              busDone,
  input  logic              busErr,
  output logic              enabled,
  output logic [CW-1:0]     remaining,
  output logic              flagHalf,
  output logic              flagDone,
  output logic              flagErr
);
  strobe_t stb;
  logic    remEmpty, lastItem, hitHalf, circQ, m2mQ;

  dmaeng_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .enWe(enWe), .enVal(enVal),
    .flagClr(flagClr), .perReq(perReq), .busDone(busDone), .busErr(busErr),
    .remEmpty(remEmpty), .lastItem(lastItem), .hitHalf(hitHalf),
    .circQ(circQ), .m2mQ(m2mQ), .stb(stb), .perAck(perAck),
    .busReq(busReq), .busWrite(busWrite), .enQ(enabled),
    .flagHalf(flagHalf), .flagDone(flagDone), .flagErr(flagErr)
  );

  dmaeng_dpath #(.AW(AW), .CW(CW)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .enQ(enabled), .cfgWe(cfgWe),
    .cfgPerBase(cfgPerBase), .cfgMemBase(cfgMemBase),
    .cfgMemIsSrc(cfgMemIsSrc), .cfgCount(cfgCount),
    .cfgPerInc(cfgPerInc), .cfgMemInc(cfgMemInc),
    .cfgPerWidth(cfgPerWidth), .cfgMemWidth(cfgMemWidth),
    .cfgCircular(cfgCircular), .cfgMemToMem(cfgMemToMem),
    .busRdata(busRdata), .busAddr(busAddr), .busSize(busSize),
    .busWdata(busWdata), .remaining(remaining), .remEmpty(remEmpty),
    .lastItem(lastItem), .hitHalf(hitHalf), .circQ(circQ), .m2mQ(m2mQ)
  );
endmodule

// File: tb/dma_chan_engine_bench.sv
`timescale 1ns/1ps
module dma_chan_engine_bench;
  localparam int AW = 16;
  localparam int CW = 8;
  localparam logic [AW-1:0] PER_BASE = 16'h0010;
  localparam logic [AW-1:0] MEM_BASE = 16'h0080;

  typedef struct packed {
    logic [1:0] pW;
    logic [1:0] mW;
    logic       pInc;
    logic       mInc;
    logic       memSrc;
    logic [7:0] cnt;
  } vec_t;

  // widths: 0 byte, 1 half, 2 word
  localparam vec_t VECS [6] = '{
    '{2'd2, 2'd2, 1'b1, 1'b1, 1'b0, 8'd4},  // word copy per->mem
    '{2'd0, 2'd0, 1'b1, 1'b1, 1'b1, 8'd5},  // byte copy mem->per
    '{2'd2, 2'd0, 1'b1, 1'b1, 1'b0, 8'd3},  // word to byte, truncate
    '{2'd0, 2'd2, 1'b1, 1'b1, 1'b0, 8'd3},  // byte to word, zero-extend
    '{2'd1, 2'd1, 1'b0, 1'b1, 1'b0, 8'd4},  // fixed source address
    '{2'd2, 2'd2, 1'b0, 1'b1, 1'b1, 8'd3}   // fixed destination address
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #5 clk = ~clk;

  logic cfgWe = 0, cfgMemIsSrc = 0, cfgPerInc = 0, cfgMemInc = 0;
  logic cfgCircular = 0, cfgMemToMem = 0, enWe = 0, enVal = 0, perReq = 0;
  logic [AW-1:0] cfgPerBase = '0, cfgMemBase = '0;
  logic [CW-1:0] cfgCount = '0;
  logic [1:0] cfgPerWidth = 0, cfgMemWidth = 0;
  logic [2:0] flagClr = 0;
  logic perAck, busReq, busWrite, busDone, busErr, enabled;
  logic flagHalf, flagDone, flagErr;
  logic [AW-1:0] busAddr;
  logic [1:0] busSize;
  logic [31:0] busWdata, busRdata;
  logic [CW-1:0] remaining;

  logic errArm = 0;
  logic [AW-1:0] errAddr = '0;
  logic [7:0] mem [256];
  logic [7:0] refMem [256];
  int ackCnt = 0, busCnt = 0;
  int nChk = 0, nBad = 0;

  dma_chan_engine #(.AW(AW), .CW(CW)) u_dma_chan_engine (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgPerBase(cfgPerBase),
    .cfgMemBase(cfgMemBase), .cfgMemIsSrc(cfgMemIsSrc), .cfgCount(cfgCount),
    .cfgPerInc(cfgPerInc), .cfgMemInc(cfgMemInc), .cfgPerWidth(cfgPerWidth),
    .cfgMemWidth(cfgMemWidth), .cfgCircular(cfgCircular),
    .cfgMemToMem(cfgMemToMem), .enWe(enWe), .enVal(enVal), .flagClr(flagClr),
    .perReq(perReq), .perAck(perAck), .busReq(busReq), .busWrite(busWrite),
    .busAddr(busAddr), .busSize(busSize), .busWdata(busWdata),
    .busRdata(busRdata), .busDone(busDone), .busErr(busErr),
    .enabled(enabled), .remaining(remaining), .flagHalf(flagHalf),
    .flagDone(flagDone), .flagErr(flagErr)
  );

  // zero-wait bus model over a 256-byte window
  logic [7:0] ba;
  assign ba       = busAddr[7:0];
  assign busErr   = busReq && errArm && (busAddr == errAddr);
  assign busDone  = busReq && !busErr;
  assign busRdata = {mem[8'(ba + 8'd3)], mem[8'(ba + 8'd2)], mem[8'(ba + 8'd1)], mem[ba]};

  always @(posedge clk) begin
    if (perAck) ackCnt++;
    if (busReq) busCnt++;
    if (busReq && busWrite && busDone) begin
      mem[ba] <= busWdata[7:0];
      if (busSize != 2'd0) mem[8'(ba + 8'd1)] <= busWdata[15:8];
      if (busSize[1]) begin
        mem[8'(ba + 8'd2)] <= busWdata[23:16];
        mem[8'(ba + 8'd3)] <= busWdata[31:24];
      end
    end
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic initMem();
    for (int i = 0; i < 256; i++) begin
      mem[i]    = 8'(i * 7 + 3);
      refMem[i] = 8'(i * 7 + 3);
    end
  endtask

  task automatic doCfg(input logic memSrc, input logic [CW-1:0] cnt,
                       input logic pInc, input logic mInc,
                       input logic [1:0] pW, input logic [1:0] mW,
                       input logic circ, input logic m2m);
    @(negedge clk);
    cfgPerBase = PER_BASE; cfgMemBase = MEM_BASE; cfgMemIsSrc = memSrc;
    cfgCount = cnt; cfgPerInc = pInc; cfgMemInc = mInc;
    cfgPerWidth = pW; cfgMemWidth = mW; cfgCircular = circ; cfgMemToMem = m2m;
    cfgWe = 1;
    @(negedge clk);
    cfgWe = 0;
  endtask

  task automatic setEn(input logic v);
    @(negedge clk);
    enWe = 1; enVal = v;
    @(negedge clk);
    enWe = 0;
  endtask

  task automatic clrFlags(input logic [2:0] bits);
    @(negedge clk);
    flagClr = bits;
    @(negedge clk);
    flagClr = 0;
  endtask

  task automatic waitOff(input int limit);
    for (int i = 0; i < limit && enabled; i++) @(negedge clk);
  endtask

  // independent model of one normal transfer
  task automatic modelRun(input vec_t v);
    int sa, da, sb, db, ss, ds;
    logic [31:0] val;
    sa = v.memSrc ? int'(MEM_BASE) : int'(PER_BASE);
    da = v.memSrc ? int'(PER_BASE) : int'(MEM_BASE);
    sb = v.memSrc ? (1 << v.mW) : (1 << v.pW);
    db = v.memSrc ? (1 << v.pW) : (1 << v.mW);
    ss = (v.memSrc ? v.mInc : v.pInc) ? sb : 0;
    ds = (v.memSrc ? v.pInc : v.mInc) ? db : 0;
    for (int n = 0; n < int'(v.cnt); n++) begin
      val = 0;
      for (int k = 0; k < sb; k++) val[8*k +: 8] = refMem[(sa + k) & 255];
      for (int k = 0; k < db; k++) refMem[(da + k) & 255] = val[8*k +: 8];
      sa += ss; da += ds;
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    nChk++; nBad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin : main
    int diffs, a0, b0, r0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!enabled && !flagHalf && !flagDone && !flagErr, "R1 enable/flags",
        {enabled, flagHalf, flagDone, flagErr}, 0);
    chk(!busReq && !perAck && remaining == 0, "R1 bus/ack/remaining",
        {busReq, perAck, 8'(remaining)}, 0);
    rstN = 1;
    @(negedge clk);

    // vector table: memory-to-memory normal transfers (R3 R4 R5 R7 R8 R10)
    foreach (VECS[vi]) begin
      initMem();
      modelRun(VECS[vi]);
      doCfg(VECS[vi].memSrc, VECS[vi].cnt, VECS[vi].pInc, VECS[vi].mInc,
            VECS[vi].pW, VECS[vi].mW, 1'b0, 1'b1);
      setEn(1);
      waitOff(200);
      diffs = 0;
      for (int i = 0; i < 256; i++) if (mem[i] !== refMem[i]) diffs++;
      chk(diffs == 0, $sformatf("R3 R4 R5 R7 vec%0d bytes differing", vi), diffs, 0);
      chk(!enabled && remaining == 0 && flagDone, $sformatf("R8 vec%0d stop", vi),
          {enabled, 8'(remaining), flagDone}, 1);
      chk(flagHalf, $sformatf("R10 vec%0d half flag", vi), flagHalf, 1);
      clrFlags(3'b111);
    end

    // R6 peripheral mode waits for a request
    initMem();
    doCfg(1'b0, 8'd3, 1'b1, 1'b1, 2'd2, 2'd2, 1'b0, 1'b0);
    b0 = busCnt; a0 = ackCnt;
    setEn(1);
    repeat (20) @(negedge clk);
    chk(busCnt == b0 && ackCnt == a0, "R6 no access without request", busCnt - b0, 0);
    chk(remaining == 3, "R6 count held", remaining, 3);

    // R2 configuration write ignored while enabled
    doCfg(1'b0, 8'd7, 1'b1, 1'b1, 2'd2, 2'd2, 1'b0, 1'b0);
    chk(remaining == 3, "R2 cfg write while enabled", remaining, 3);

    // R6 R10 two requests, then pause
    perReq = 1;
    for (int i = 0; i < 100 && ackCnt < a0 + 2; i++) @(negedge clk);
    perReq = 0;
    repeat (10) @(negedge clk);
    chk(ackCnt == a0 + 2, "R6 one ack per item", ackCnt - a0, 2);
    chk(remaining == 1 && flagHalf && !flagDone, "R10 half after two of three",
        {8'(remaining), flagHalf, flagDone}, {8'd1, 2'b10});
    perReq = 1;
    waitOff(100);
    perReq = 0;
    chk(ackCnt == a0 + 3 && flagDone, "R6 R8 peripheral run done", ackCnt - a0, 3);
    chk({mem[8'h83], mem[8'h82], mem[8'h81], mem[8'h80]} ==
        {8'(8'h13 * 7 + 3), 8'(8'h12 * 7 + 3), 8'(8'h11 * 7 + 3), 8'(8'h10 * 7 + 3)},
        "R3 peripheral word landed", mem[8'h80], 8'(8'h10 * 7 + 3));

    // R13 write-one-to-clear only affects its bit
    clrFlags(3'b010);
    chk(!flagDone && flagHalf, "R13 selective clear", {flagDone, flagHalf}, 2'b01);
    clrFlags(3'b001);

    // R9 circular mode keeps running
    initMem();
    doCfg(1'b1, 8'd2, 1'b1, 1'b1, 2'd2, 2'd2, 1'b1, 1'b1);
    setEn(1);
    for (int i = 0; i < 100 && !flagDone; i++) @(negedge clk);
    chk(flagDone && enabled, "R9 still enabled after a lap", {flagDone, enabled}, 2'b11);
    repeat (7) @(negedge clk);
    chk(remaining != 0, "R9 count reloaded", remaining, 2);
    chk(mem[8'h10] == 8'(8'h80 * 7 + 3) && mem[8'h14] == 8'(8'h84 * 7 + 3),
        "R9 R3 circular data", mem[8'h14], 8'(8'h84 * 7 + 3));

    // R12 abort
    setEn(0);
    r0 = remaining; b0 = busCnt;
    repeat (10) @(negedge clk);
    chk(busCnt == b0 && remaining == r0 && !enabled, "R12 abort quiet",
        busCnt - b0, 0);
    clrFlags(3'b111);

    // R11 bus error on the second read
    initMem();
    errAddr = MEM_BASE + 16'd4; errArm = 1;
    doCfg(1'b1, 8'd4, 1'b1, 1'b1, 2'd2, 2'd2, 1'b0, 1'b1);
    setEn(1);
    waitOff(100);
    errArm = 0;
    chk(flagErr && !enabled, "R11 error stops", {flagErr, enabled}, 2'b10);
    chk(remaining == 3, "R11 failed item not counted", remaining, 3);
    chk(!flagDone, "R11 no completion", flagDone, 0);
    clrFlags(3'b100);
    chk(!flagErr, "R13 error flag cleared", flagErr, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule